// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Selectable Read Pipelining

This block is a compact synchronous static memory for use inside a larger design. Every command is sampled on the rising clock edge. Three chip enables select the device. A write either updates the byte lanes named by per-lane strobes, qualified by a lane-write enable, or stores the whole word through a global write. Any selected cycle that is not a write is a read.

A static mode input chooses between two read timings. In flow-through mode a word is presented in the cycle after its sampling edge. In pipelined mode it comes one cycle later. Deselects travel down the same pipeline as reads, so the bus stays driven by earlier read data until that data has drained. The output enable gates the bus asynchronously. A sleep input blocks every access but keeps the stored contents. Burst address sequencing is the caller's job, and a new address can be issued on every cycle.

The data bus is modelled as a data vector plus a drive-enable flag. When the flag is low the bus counts as high-impedance.

Top module: `bytewide_sync_sram`

## Requirements
- R1: While reset is held and after it is released, with no read issued, `doutEn` is 0.
- R2: With `flowThru`=0, a read sampled at edge k drives `doutEn`=1 and `dout`=the stored word in the cycle between edge k+1 and edge k+2, and not before.
- R3: With `flowThru`=1, a read sampled at edge k drives `doutEn`=1 and `dout`=the stored word in the cycle between edge k and edge k+1.
- R4: A cycle with `wrByteN`=0 and at least one `laneN` bit at 0 writes only the lanes whose `laneN` bit is 0. Lane i is `din[8i+7:8i]`.
- R5: A cycle with `wrAllN`=0 writes all lanes, whatever the values of `wrByteN` and `laneN`.
- R6: A selected cycle with `wrAllN`=1 and either `wrByteN`=1 or all `laneN` bits at 1 is a read and leaves memory unchanged.
- R7: The device is selected only when `ceAN`=0, `ceB`=1 and `ceCN`=0. A cycle with any enable inactive is a deselect: nothing is written and nothing new is read.
- R8: A deselect sampled at edge k turns the bus off after edge k+1 in pipelined mode and after edge k in flow-through mode. A read at edge k-1 in pipelined mode therefore stays driven in the cycle after edge k.
- R9: `oeN`=1 forces `doutEn` to 0 at once, without waiting for a clock edge. Returning `oeN` to 0 restores the pending read data.
- R10: While `sleep`=1, reads and writes are ignored and `doutEn` is 0. Contents written before sleep are read back unchanged after it.
- R11: A write cycle never drives the bus. A write at edge k leaves `doutEn` at 0 in the slot where a read at edge k would have been driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset of the pipeline state |
| flowThru | input | 1 | Static mode select: 1 = flow-through, 0 = pipelined |
| ceAN | input | 1 | Chip enable, active low |
| ceB | input | 1 | Chip enable, active high |
| ceCN | input | 1 | Chip enable, active low |
| wrAllN | input | 1 | Global write, active low |
| wrByteN | input | 1 | Lane-write enable, active low |
| laneN | input | NBYTES | Per-lane write strobes, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request, active high |
| addr | input | ADDR_W | Word address |
| din | input | NBYTES*BYTE_W | Write data |
| dout | output | NBYTES*BYTE_W | Read data, 0 when not driven |
| doutEn | output | 1 | Bus drive flag; 0 means high-impedance |

## Verification
On every cycle, the assertions check the read-to-drive latency in both modes: a driven bus must trace back to a read accepted one or two edges earlier. They also check that no write goes out with an empty lane mask and that sleep blocks all writes. Whether the right bytes land in the right lanes, what the asynchronous output enable does, how the bus drains after a deselect, and whether data survives sleep can only be shown by the bench scenarios, which compare read-back words against a reference memory.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic memWe;   // write the lanes in laneMask at this edge
    logic takeRd;  // capture the read address at this edge
    logic useFlow; // present the array word directly
  } sbsStb_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowThru,
  input  logic              ceAN,
  input  logic              ceB,
  input  logic              ceCN,
  input  logic              wrAllN,
  input  logic              wrByteN,
  input  logic [NBYTES-1:0] laneN,
  input  logic              oeN,
  input  logic              sleep,
  output sbsStb_t           stb,
  output logic [NBYTES-1:0] laneMask,
  output logic              doutEn
);
  logic selected, anyLane, wrCmd, rdCmd;
  logic s1Read, s2Read, stageRead;

  assign selected = !ceAN && ceB && !ceCN && !sleep;
  assign anyLane  = |(~laneN);
  assign wrCmd    = selected && (!wrAllN || (!wrByteN && anyLane));
  assign rdCmd    = selected && !wrCmd;

  always_comb begin
    if (!wrAllN)       laneMask = '1;
    else if (!wrByteN) laneMask = ~laneN;
    else               laneMask = '0;
  end

  // A deselect or write moves through the same stages as a read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Read <= 1'b0;
      s2Read <= 1'b0;
    end else begin
      s1Read <= rdCmd;
      s2Read <= s1Read;
    end
  end

  assign stageRead = flowThru ? s1Read : s2Read;
  assign doutEn    = stageRead && !oeN && !sleep;

  assign stb.memWe   = wrCmd;
  assign stb.takeRd  = rdCmd;
  assign stb.useFlow = flowThru;

  // R2: a pipelined drive needs a read two edges back
  p_pipe_lat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!flowThru && doutEn) |-> $past(rdCmd, 2));

  // R3: a flow-through drive needs a read one edge back
  p_flow_lat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (flowThru && doutEn) |-> $past(rdCmd));

  // R10: sleep blocks every write strobe
  p_sleep_nowr_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !stb.memWe);
endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sbsStb_t                  stb,
  input  logic [NBYTES-1:0]        laneMask,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] rawOut
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = NBYTES * BYTE_W;

  logic [ADDR_W-1:0] rdAddr;
  logic [WORD_W-1:0] flowWord, pipeWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdAddr <= '0;
    else if (stb.takeRd) rdAddr <= addr;
  end

  // one storage array per byte lane, each with its own write gate
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (stb.memWe && laneMask[g]) store[addr] <= din[g*BYTE_W +: BYTE_W];
    end
    assign flowWord[g*BYTE_W +: BYTE_W] = store[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipeWord <= '0;
    else       pipeWord <= flowWord;
  end

  assign rawOut = stb.useFlow ? flowWord : pipeWord;

  // R4: a write strobe always carries at least one lane
  p_we_lanes_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWe |-> (laneMask != '0));
endmodule

// File: rtl/bytewide_sync_sram.sv
module bytewide_sync_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flowThru,
  input  logic                     ceAN,
  input  logic                     ceB,
  input  logic                     ceCN,
  input  logic                     wrAllN,
  input  logic                     wrByteN,
  input  logic [NBYTES-1:0]        laneN,
  input  logic                     oeN,
  input  logic                     sleep,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     doutEn
);
  sbsStb_t                  stb;
  logic [NBYTES-1:0]        laneMask;
  logic [NBYTES*BYTE_W-1:0] rawOut;

  sbs_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flowThru(flowThru),
    .ceAN(ceAN), .ceB(ceB), .ceCN(ceCN),
    .wrAllN(wrAllN), .wrByteN(wrByteN), .laneN(laneN),
    .oeN(oeN), .sleep(sleep),
    .stb(stb), .laneMask(laneMask), .doutEn(doutEn)
  );

  sbs_datapath #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .laneMask(laneMask),
    .addr(addr), .din(din), .rawOut(rawOut)
  );

  assign dout = doutEn ? rawOut : '0;
endmodule

// File: tb/tb_bytewide_sync_sram.sv
module tb_bytewide_sync_sram;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, flowThru, ceAN, ceB, ceCN, wrAllN, wrByteN, oeN, sleep;
  logic [NB-1:0] laneN;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic doutEn;

  bytewide_sync_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(8)) dut (
    .clk(clk), .rstN(rstN), .flowThru(flowThru),
    .ceAN(ceAN), .ceB(ceB), .ceCN(ceCN),
    .wrAllN(wrAllN), .wrByteN(wrByteN), .laneN(laneN),
    .oeN(oeN), .sleep(sleep), .addr(addr), .din(din),
    .dout(dout), .doutEn(doutEn)
  );

  int nChk = 0, nBad = 0;
  logic [DW-1:0] mdl [1<<AW];
  logic e1Rd = 1'b0, e2Rd = 1'b0;
  logic [DW-1:0] e1Val = '0, e2Val = '0;

  function automatic logic [DW-1:0] mergeLanes(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NB; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic logic expDrive();
    return (flowThru ? e1Rd : e2Rd) && !oeN && !sleep;
  endfunction

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic setIdle();
    ceAN = 1'b0; ceB = 1'b0; ceCN = 1'b0; wrAllN = 1'b1; wrByteN = 1'b1; laneN = '1;
  endtask
  task automatic setRead(logic [AW-1:0] a);
    ceAN = 1'b0; ceB = 1'b1; ceCN = 1'b0; wrAllN = 1'b1; wrByteN = 1'b1; laneN = '1; addr = a;
  endtask
  task automatic setWrAll(logic [AW-1:0] a, logic [DW-1:0] d);
    setRead(a); wrAllN = 1'b0; din = d;
  endtask
  task automatic setWrLane(logic [AW-1:0] a, logic [DW-1:0] d, logic [NB-1:0] ln);
    setRead(a); wrByteN = 1'b0; laneN = ln; din = d;
  endtask

  // one clock: update the reference at the edge, compare 3 ns later
  task automatic step(string tag);
    logic sel, wr;
    logic [NB-1:0] m;
    @(posedge clk);
    sel = !ceAN && ceB && !ceCN && !sleep;
    wr  = sel && (!wrAllN || (!wrByteN && laneN != '1));
    m   = !wrAllN ? '1 : ~laneN;
    e2Rd = e1Rd; e2Val = e1Val;
    e1Rd = sel && !wr; e1Val = mdl[addr];
    if (wr) mdl[addr] = mergeLanes(mdl[addr], din, m);
    #3;
    check({tag, " drive"}, {31'd0, doutEn}, {31'd0, expDrive()});
    if (expDrive()) check({tag, " data"}, dout, flowThru ? e1Val : e2Val);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int unsigned seed = $urandom(32'd2024);
    rstN = 1'b0; flowThru = 1'b0; oeN = 1'b0; sleep = 1'b0; addr = '0; din = '0;
    setIdle();
    for (int i = 0; i < (1<<AW); i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #3 check("R1 reset", {31'd0, doutEn}, 32'd0);
    rstN = 1'b1;
    step("R1 idle");

    // fill the memory through global writes (R5, R11)
    for (int i = 0; i < (1<<AW); i++) begin
      setWrAll(i[AW-1:0], {8'hA0 ^ i[7:0], i[7:0], 8'h5C, 8'h3E ^ i[7:0]});
      step("R11 fill");
    end

    // pipelined latency and deselect drain (R2, R8)
    setRead(6'd5);  step("R2 read");
    setRead(6'd9);  step("R2 read2");
    setIdle();      step("R8 drain");
    step("R8 off");
    step("R8 quiet");

    // byte-lane write, then read (R4)
    setWrLane(6'd5, 32'h11223344, 4'b1010); step("R4 lanes");
    setRead(6'd5); step("R4 read"); setIdle(); step("R4 rd"); step("R4 end");

    // global write ignores lane controls (R5)
    setWrAll(6'd7, 32'hDEADBEEF); wrByteN = 1'b1; laneN = '1; step("R5 gw");
    setRead(6'd7); step("R5 read"); setIdle(); step("R5 rd"); step("R5 end");

    // lane enable with no strobes is a read (R6)
    setWrLane(6'd7, 32'h0, 4'b1111); step("R6 nolane");
    setIdle(); step("R6 rd"); step("R6 end");

    // each enable off blocks a write (R7)
    setWrAll(6'd8, 32'hFFFF0000); ceAN = 1'b1; step("R7 ceA");
    setWrAll(6'd8, 32'hFFFF0001); ceB  = 1'b0; step("R7 ceB");
    setWrAll(6'd8, 32'hFFFF0002); ceCN = 1'b1; step("R7 ceC");
    setRead(6'd8); step("R7 read"); setIdle(); step("R7 rd"); step("R7 end");

    // flow-through mode (R3, R8, R11)
    flowThru = 1'b1; step("R3 mode");
    setRead(6'd9);  step("R3 read");
    setWrAll(6'd9, 32'h0BADF00D); step("R11 wr");
    setRead(6'd9);  step("R3 readback");
    setIdle();      step("R8 flow off");

    // asynchronous output enable (R9)
    setRead(6'd3); step("R9 read"); setIdle();
    #1 oeN = 1'b1; #1 check("R9 oe off", {31'd0, doutEn}, 32'd0);
    oeN = 1'b0; #1 check("R9 oe on", dout, mdl[3]);
    step("R9 end");

    // sleep blocks access and keeps data (R10)
    sleep = 1'b1;
    setWrAll(6'd3, 32'h12345678); step("R10 wr");
    setRead(6'd3); step("R10 rd");
    sleep = 1'b0; setRead(6'd3); step("R10 wake");
    check("R10 kept", dout, {8'hA0 ^ 8'd3, 8'd3, 8'h5C, 8'h3E ^ 8'd3});
    setIdle(); step("R10 end");

    // constrained random traffic in both modes
    for (int ph = 0; ph < 4; ph++) begin
      setIdle(); step("R8 gap"); step("R8 gap");
      flowThru = ph[0]; step("R2 R3 mode");
      for (int n = 0; n < 150; n++) begin
        int unsigned k = $urandom % 10;
        logic [AW-1:0] a = AW'($urandom % 16);
        logic [DW-1:0] d = $urandom;
        if (k < 4)       setRead(a);
        else if (k < 6)  setWrAll(a, d);
        else if (k < 8)  setWrLane(a, d, NB'($urandom));
        else             setIdle();
        if (k == 9) begin ceAN = $urandom; ceB = $urandom; ceCN = $urandom; end
        oeN = ($urandom % 8) == 0;
        step("R2 R3 R4 R7 rand");
      end
      oeN = 1'b0;
    end
    setIdle(); step("R1 final");
    finishRun();
  end
  initial if (seed_unused()) ;
  function automatic bit seed_unused(); return 1'b0; endfunction
endmodule